// File: doc/BRIEF.md
# Banked Interrupt Group Register File

This block keeps the group assignment of every interrupt in a distributor: group 0 (secure) or group 1 (non-secure). Software reaches the bits through a byte-wide register window. Each byte covers eight consecutive interrupt IDs. The block checks each access against two configuration inputs and the secure attribute of the access. When the access is not permitted, reads return zero and writes are dropped without any error.

Interrupt IDs below 32 are private to each CPU. Each CPU therefore holds its own copy of their group bits. The bits of shared interrupts are held once and seen identically by every CPU. The rest of the controller receives a flat vector with each CPU's view of every interrupt's group.

Top module: `grp_regfile`

## Requirements
- R1: While reset is asserted, and right after it is released, every group bit in every CPU's view is 0, and `rsp_valid` is 0.
- R2: The window occupies byte offsets 0x80 to 0xFF. Bit i of the byte at offset o belongs to interrupt (o − 0x80)·8 + i. A permitted write of 1 puts that interrupt in group 1 and a write of 0 puts it in group 0. The new value appears on `grp_out` the cycle after the request.
- R3: Every request gets a response: `rsp_valid`, `rsp_rdata` and `rsp_err` are registered and valid exactly one cycle after the request. A permitted read returns the eight bits of the addressed byte as seen by the requesting CPU. A write response always carries `rsp_rdata` = 0.
- R4: A write to a byte covering interrupts 0–31 changes only the requesting CPU's copy. A read of that byte returns the requesting CPU's copy.
- R5: A write to a byte covering interrupts 32 and above changes that interrupt's bit in every CPU's view. Every CPU's view of a shared interrupt is always the same.
- R6: When neither `cfg_rev2` nor `cfg_secext` is 1, groups do not exist. Every window access then reads 0, changes nothing and reports no error, even at offsets beyond the interrupt count.
- R7: When `cfg_secext` = 1 and `req_secure` = 0, window accesses read 0, change nothing and report no error. When `cfg_secext` = 0 and `cfg_rev2` = 1, non-secure accesses are permitted.
- R8: A permitted access whose first interrupt, (o − 0x80)·8, is at or beyond NUM_IRQ returns `rsp_err` = 1 and `rsp_rdata` = 0, and changes no state.
- R9: An access outside 0x80–0xFF returns 0 with no error and changes nothing.
- R10: `grp_out[c*NUM_IRQ + n]` is the group bit of interrupt n as seen by CPU c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rev2 | input | 1 | Controller configured as the revision that always has groups |
| cfg_secext | input | 1 | Security extension present |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the distributor space |
| req_wdata | input | 8 | Write byte |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_secure | input | 1 | Access carries the secure attribute |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_rdata | output | 8 | Read byte |
| rsp_err | output | 1 | Bad-register error |
| grp_out | output | NUM_CPU*NUM_IRQ | Group bit of each interrupt as seen by each CPU |

## Verification
The block has two kinds of result. The response fields come one register stage after the request. A permitted write shows up on `grp_out` at the same edge. The bench therefore drives each request on a falling edge and lowers `req_valid` on the next falling edge. It then compares both the response and the whole `grp_out` vector against its own bank model at that same falling edge, before it drives anything else. Gated and out-of-range cases are checked in the same way, by showing that `grp_out` and later reads are unchanged.

// File: rtl/grp_pkg.sv
package grp_pkg;

    // Window placement and private-interrupt boundary
    localparam int WIN_BASE  = 128;
    localparam int WIN_BYTES = 128;
    localparam int PRIV_IRQ  = 32;
    localparam int IDX_W     = 7;

    typedef struct packed {
        logic              hit;      // request falls inside the window
        logic              allowed;  // security/config permit the access
        logic              bad;      // permitted but beyond interrupt count
        logic [IDX_W-1:0]  idx;      // byte index inside the window
    } grp_acc_t;

endpackage

// File: rtl/grp_decode.sv
module grp_decode
    import grp_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 12
) (
    input  logic              cfg_rev2,
    input  logic              cfg_secext,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_secure,
    output grp_acc_t          acc
);

    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + WIN_BYTES);

    logic has_groups;
    logic ns_blocked;

    always_comb begin
        has_groups  = cfg_rev2 | cfg_secext;
        ns_blocked  = cfg_secext & ~req_secure;
        acc.hit     = req_valid && (req_addr >= WIN_LO) && (req_addr < WIN_HI);
        acc.allowed = has_groups & ~ns_blocked;
        acc.idx     = req_addr[IDX_W-1:0];
        acc.bad     = acc.hit && acc.allowed &&
                      ((int'(acc.idx) * 8) >= NUM_IRQ);
    end

endmodule

// File: rtl/grp_store.sv
module grp_store
    import grp_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64,
    parameter int CPU_W   = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [CPU_W-1:0]                  wr_cpu,
    input  logic [7:0]                        wr_data,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]   view
);

    localparam int SHR   = NUM_IRQ - PRIV_IRQ;
    localparam int SHR_W = (SHR > 0) ? SHR : 1;

    typedef struct packed {
        logic [NUM_CPU-1:0][PRIV_IRQ-1:0] bank;
        logic [SHR_W-1:0]                 shr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // banked private bits: only the requesting CPU's copy
            for (int c = 0; c < NUM_CPU; c++) begin
                for (int n = 0; n < PRIV_IRQ; n++) begin
                    if (wr_cpu == CPU_W'(c) && wr_idx == IDX_W'(n / 8)) begin
                        st_d.bank[c][n] = wr_data[n % 8];
                    end
                end
            end
            // shared bits: one copy seen by all CPUs
            if (SHR > 0) begin
                for (int j = 0; j < SHR_W; j++) begin
                    if (wr_idx == IDX_W'((j + PRIV_IRQ) / 8)) begin
                        st_d.shr[j] = wr_data[(j + PRIV_IRQ) % 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_view
        assign view[c][PRIV_IRQ-1:0] = st_q.bank[c];
        if (SHR > 0) begin : g_shr
            assign view[c][NUM_IRQ-1:PRIV_IRQ] = st_q.shr;
        end
    end

endmodule

// File: rtl/grp_rsp.sv
module grp_rsp
    import grp_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64,
    parameter int CPU_W   = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic                             req_write,
    input  logic [CPU_W-1:0]                 req_cpu,
    input  grp_acc_t                         acc,
    input  logic [NUM_CPU-1:0][NUM_IRQ-1:0]  view,
    output logic                             rsp_valid,
    output logic [7:0]                       rsp_rdata,
    output logic                             rsp_err
);

    localparam int NBYTE = NUM_IRQ / 8;

    typedef struct packed {
        logic       vld;
        logic [7:0] rd;
        logic       err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic [7:0] sel_byte;

    always_comb begin
        sel_byte = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (req_cpu == CPU_W'(c) && acc.idx == IDX_W'(b)) begin
                    sel_byte = view[c][b*8 +: 8];
                end
            end
        end

        rsp_d     = '0;
        rsp_d.vld = req_valid;
        rsp_d.err = acc.bad;
        if (acc.hit && acc.allowed && !acc.bad && !req_write) begin
            rsp_d.rd = sel_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_rdata = rsp_q.rd;
    assign rsp_err   = rsp_q.err;

endmodule

// File: rtl/grp_regfile.sv
module grp_regfile
    import grp_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 12,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_rev2,
    input  logic                       cfg_secext,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [7:0]                 req_wdata,
    input  logic [CPU_W-1:0]           req_cpu,
    input  logic                       req_secure,
    output logic                       rsp_valid,
    output logic [7:0]                 rsp_rdata,
    output logic                       rsp_err,
    output logic [NUM_CPU*NUM_IRQ-1:0] grp_out
);

    grp_acc_t                        acc;
    logic                            wr_en;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0] view;

    grp_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_dec (
        .cfg_rev2   (cfg_rev2),
        .cfg_secext (cfg_secext),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_secure (req_secure),
        .acc        (acc)
    );

    assign wr_en = acc.hit & acc.allowed & ~acc.bad & req_write;

    grp_store #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (acc.idx),
        .wr_cpu  (req_cpu),
        .wr_data (req_wdata),
        .view    (view)
    );

    grp_rsp #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cpu   (req_cpu),
        .acc       (acc),
        .view      (view),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    assign grp_out = view;

endmodule

// File: rtl/grp_regfile_chk.sv
module grp_regfile_chk #(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 12,
    parameter int CPU_W   = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_rev2,
    input logic                       cfg_secext,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [CPU_W-1:0]           req_cpu,
    input logic                       req_secure,
    input logic                       rsp_valid,
    input logic [7:0]                 rsp_rdata,
    input logic                       rsp_err,
    input logic [NUM_CPU*NUM_IRQ-1:0] grp_out
);

    logic in_win;
    logic off_end;
    logic unused_cpu;

    assign in_win     = (int'(req_addr) >= 128) && (int'(req_addr) < 256);
    assign off_end    = ((int'(req_addr) - 128) * 8) >= NUM_IRQ;
    assign unused_cpu = ^req_cpu;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (grp_out == '0 && !rsp_valid));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(grp_out));

    assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_nogroups_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_rev2 && !cfg_secext) |=>
            (rsp_rdata == 8'h00 && !rsp_err && $stable(grp_out)));

    assert_ns_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_secext && !req_secure) |=>
            (rsp_rdata == 8'h00 && !rsp_err && $stable(grp_out)));

    assert_err_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 8'h00));

    assert_err_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_win && off_end && (cfg_rev2 || cfg_secext) &&
         !(cfg_secext && !req_secure)) |=> (rsp_err && $stable(grp_out)));

    assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_win) |=>
            (rsp_rdata == 8'h00 && !rsp_err && $stable(grp_out)));

    if (NUM_IRQ > 32) begin : g_shared
        for (genvar c = 1; c < NUM_CPU; c++) begin : g_cpu
            assert_shared_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
                grp_out[c*NUM_IRQ+32 +: NUM_IRQ-32] == grp_out[32 +: NUM_IRQ-32]);
        end
    end

    always_comb begin
        if (rst_n && unused_cpu && 1'b0) begin
            $display("unreachable");
        end
    end

endmodule

bind grp_regfile grp_regfile_chk #(
    .NUM_CPU (NUM_CPU),
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W),
    .CPU_W   (CPU_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rev2   (cfg_rev2),
    .cfg_secext (cfg_secext),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_cpu    (req_cpu),
    .req_secure (req_secure),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .grp_out    (grp_out)
);

// File: tb/grp_regfile_test.sv
`timescale 1ns/1ps
module grp_regfile_test;

    localparam int NCPU = 2;
    localparam int NIRQ = 64;
    localparam int AW   = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_rev2 = 1'b1;
    logic             cfg_secext = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [7:0]       req_wdata = '0;
    logic [0:0]       req_cpu = '0;
    logic             req_secure = 1'b1;
    logic             rsp_valid;
    logic [7:0]       rsp_rdata;
    logic             rsp_err;
    logic [NCPU*NIRQ-1:0] grp_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [NCPU*NIRQ-1:0] model = '0;

    always #4 clk = ~clk;

    grp_regfile #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ), .ADDR_W(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_rev2   (cfg_rev2),
        .cfg_secext (cfg_secext),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_cpu    (req_cpu),
        .req_secure (req_secure),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .grp_out    (grp_out)
    );

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [0:0]  cpu;
        logic [11:0] addr;
        logic [7:0]  wd;
        logic [7:0]  exp;
        logic        experr;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 12'h080, 8'h00, 8'h00, 1'b0}, // R2 fresh read
        '{1'b1, 1'b1, 1'b0, 12'h080, 8'hA5, 8'h00, 1'b0}, // R2 write
        '{1'b0, 1'b1, 1'b0, 12'h080, 8'h00, 8'hA5, 1'b0}, // R3 readback
        '{1'b0, 1'b1, 1'b1, 12'h080, 8'h00, 8'h00, 1'b0}, // R4 other bank
        '{1'b1, 1'b1, 1'b1, 12'h083, 8'h3C, 8'h00, 1'b0}, // R4 cpu1 write
        '{1'b0, 1'b1, 1'b1, 12'h083, 8'h00, 8'h3C, 1'b0}, // R4
        '{1'b0, 1'b1, 1'b0, 12'h083, 8'h00, 8'h00, 1'b0}, // R4
        '{1'b1, 1'b1, 1'b0, 12'h084, 8'hF0, 8'h00, 1'b0}, // R5 shared
        '{1'b0, 1'b1, 1'b1, 12'h084, 8'h00, 8'hF0, 1'b0}, // R5
        '{1'b1, 1'b1, 1'b1, 12'h087, 8'h81, 8'h00, 1'b0}, // R5
        '{1'b0, 1'b1, 1'b0, 12'h087, 8'h00, 8'h81, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b0, 12'h080, 8'h00, 8'h00, 1'b0}, // R7 ns read
        '{1'b1, 1'b0, 1'b0, 12'h084, 8'hFF, 8'h00, 1'b0}, // R7 ns write
        '{1'b0, 1'b1, 1'b0, 12'h084, 8'h00, 8'hF0, 1'b0}, // R7 unchanged
        '{1'b0, 1'b1, 1'b0, 12'h088, 8'h00, 8'h00, 1'b1}, // R8 first bad
        '{1'b1, 1'b1, 1'b1, 12'h088, 8'hFF, 8'h00, 1'b1}, // R8 bad write
        '{1'b0, 1'b1, 1'b0, 12'h09F, 8'h00, 8'h00, 1'b1}, // R8 last byte
        '{1'b0, 1'b1, 1'b0, 12'h07F, 8'h00, 8'h00, 1'b0}, // R9 below
        '{1'b1, 1'b1, 1'b0, 12'h100, 8'hFF, 8'h00, 1'b0}, // R9 above
        '{1'b0, 1'b1, 1'b1, 12'h087, 8'h00, 8'h81, 1'b0}  // R9 unchanged
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Independent model of the requirements, applied after a request
    task automatic model_update(input logic wr, input logic sec, input logic [0:0] cpu,
                                input logic [11:0] addr, input logic [7:0] wd);
        int base;
        bit allowed;
        allowed = (cfg_rev2 || cfg_secext) && !(cfg_secext && !sec);
        base = (int'(addr) - 128) * 8;
        if (wr && allowed && addr >= 12'h080 && addr <= 12'h0FF && base < NIRQ) begin
            for (int i = 0; i < 8; i++) begin
                if (base + i < 32) begin
                    model[int'(cpu)*NIRQ + base + i] = wd[i];
                end else begin
                    for (int c = 0; c < NCPU; c++) model[c*NIRQ + base + i] = wd[i];
                end
            end
        end
    endtask

    task automatic access(input logic wr, input logic sec, input logic [0:0] cpu,
                          input logic [11:0] addr, input logic [7:0] wd,
                          input logic [7:0] exp, input logic experr, input string req);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_secure = sec;
        req_cpu    = cpu;
        req_addr   = addr;
        req_wdata  = wd;
        @(negedge clk);
        req_valid  = 1'b0;
        req_write  = 1'b0;
        model_update(wr, sec, cpu, addr, wd);
        check(rsp_valid === 1'b1, req, "rsp_valid", 128'(rsp_valid), 128'(1));
        check(rsp_rdata === exp, req, "rsp_rdata", 128'(rsp_rdata), 128'(exp));
        check(rsp_err === experr, req, "rsp_err", 128'(rsp_err), 128'(experr));
        check(grp_out === model, "R10", "grp_out", 128'(grp_out), 128'(model));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(grp_out === '0, "R1", "grp_out in reset", 128'(grp_out), 128'(0));
        check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 128'(rsp_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(grp_out === '0, "R1", "grp_out after reset", 128'(grp_out), 128'(0));

        for (int k = 0; k < NV; k++) begin
            access(VECS[k].wr, VECS[k].sec, VECS[k].cpu, VECS[k].addr,
                   VECS[k].wd, VECS[k].exp, VECS[k].experr, "R2/R3 table");
        end

        // R6: no groups at all
        cfg_rev2 = 1'b0; cfg_secext = 1'b0;
        access(1'b0, 1'b1, 1'b0, 12'h080, 8'h00, 8'h00, 1'b0, "R6");
        access(1'b1, 1'b1, 1'b0, 12'h080, 8'h00, 8'h00, 1'b0, "R6");
        access(1'b0, 1'b1, 1'b0, 12'h090, 8'h00, 8'h00, 1'b0, "R6");

        // R7: without the security extension, non-secure access is allowed
        cfg_rev2 = 1'b1; cfg_secext = 1'b0;
        access(1'b1, 1'b0, 1'b0, 12'h080, 8'h0F, 8'h00, 1'b0, "R7");
        access(1'b0, 1'b0, 1'b0, 12'h080, 8'h00, 8'h0F, 1'b0, "R7");
        access(1'b0, 1'b0, 1'b1, 12'h084, 8'h00, 8'hF0, 1'b0, "R7");

        // R3: no request, no response
        @(negedge clk);
        check(rsp_valid === 1'b0, "R3", "idle rsp_valid", 128'(rsp_valid), 128'(0));

        // R1: reset again clears all banks
        rst_n = 1'b0;
        @(negedge clk);
        model = '0;
        check(grp_out === '0, "R1", "grp_out after re-reset", 128'(grp_out), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 1'b1, 1'b1, 12'h083, 8'h00, 8'h00, 1'b0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule